// File: doc/BRIEF.md
# Branch Resolution and Program Counter Update

This block resolves branches and jumps in the memory-access stage of a simple five-stage integer pipeline. Each cycle it may receive one instruction packet. The packet carries a control-operation code and a set of condition status bits that the execute stage has already computed. It also carries a signed relative offset, an absolute jump target, and the low bits of a source register for register-indirect jumps. The block keeps the architectural program counter, counted in instruction units.

A control transfer has exactly one delay slot, and the instruction in that slot always executes. When a branch or jump resolves, the block sends a one-cycle redirect pulse to the fetch stage, which is holding while it waits. The pulse releases fetch and carries the address it must load into its prefetch counter. If the branch is taken, that address is the target. If it is not taken, it is the instruction after the delay slot. The pulse fires in both cases and carries a taken flag. The two link variants also issue a register-write request that places the return address in the link register.

All outputs are registered. A result appears in the cycle after the packet is presented.

Top module: `br_resolve`

## Requirements
- R1: After synchronous reset the program counter is 0, and no redirect or link write is driven.
- R2: An invalid input packet (in_valid=0) leaves the program counter unchanged and produces neither a redirect nor a link write.
- R3: A valid packet with operation code 0 (no control transfer), outside a delay slot, advances the program counter by one. It produces no redirect.
- R4: Operation codes 1 to 8 are conditional branches, and their condition is decoded from in_flags. Bit 0 means the two operands are equal, bit 1 means operand A is zero, and bit 2 means operand A is negative. The conditions are: 1 equal, 2 not equal, 3 A<=0, 4 A>0, 5 A<0, 6 A>=0, 7 A<0 with link, 8 A>=0 with link.
- R5: A taken conditional branch at address P targets P + in_offset (signed, modulo 2^PC_W).
- R6: Code 9 is an absolute jump to in_abs_target. Code 10 is a register jump to in_reg_target. Both are always taken.
- R7: In the cycle after a control packet at address P, redir_valid is 1 for one cycle, and the program counter reads P+1 (the delay slot). redir_target is the target when taken and P+2 when not taken. redir_taken reports which of the two applies.
- R8: The packet after a control packet is the delay slot and always executes. It moves the program counter to the resolved next address, and it never produces a redirect, even if it holds a control code.
- R9: Codes 7 and 8 always request a write of P+2 to register 31 (link_we, link_idx, link_data) in the same cycle as the redirect. No other code writes the link register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet valid |
| in_op | input | 4 | Control-operation code |
| in_flags | input | 3 | Condition status from execute: {neg, zero, eq} |
| in_offset | input | OFF_W | Signed relative branch offset |
| in_abs_target | input | PC_W | Absolute jump target |
| in_reg_target | input | PC_W | Low bits of the source register for register jump |
| pc | output | PC_W | Architectural program counter |
| redir_valid | output | 1 | One-cycle release/redirect pulse to fetch |
| redir_taken | output | 1 | Redirect is a taken transfer |
| redir_target | output | PC_W | Address for the fetch prefetch counter |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | DATA_W | Return address to write |

## Verification
Assertions check several rules on every cycle. A redirect pulse never lasts two cycles, because the delay slot cannot redirect. A bubble leaves the counter and the redirect quiet. A not-taken redirect always points one past the delay slot. A link write comes only with a redirect and carries the address after the delay slot. Other behaviour is shown only by the bench's sweep over every operation code, every flag pattern and forward and backward offsets. That sweep covers the correctness of each condition decode, the taken targets, and where the counter lands after the delay slot. A further scenario shows that a control code placed in a delay slot is ignored.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_BEQ    = 4'd1,
    OP_BNE    = 4'd2,
    OP_BLEZ   = 4'd3,
    OP_BGTZ   = 4'd4,
    OP_BLTZ   = 4'd5,
    OP_BGEZ   = 4'd6,
    OP_BLTZL  = 4'd7,
    OP_BGEZL  = 4'd8,
    OP_JABS   = 4'd9,
    OP_JREG   = 4'd10
  } ctl_op_e;

  localparam int FLAG_EQ   = 0;
  localparam int FLAG_ZERO = 1;
  localparam int FLAG_NEG  = 2;
  localparam int FLAGS_W   = 3;

  typedef enum logic [1:0] {
    TGT_NEXT = 2'd0,
    TGT_REL  = 2'd1,
    TGT_ABS  = 2'd2,
    TGT_REG  = 2'd3
  } tgt_sel_e;
endpackage

// File: rtl/br_cond.sv
module br_cond
  import br_resolve_pkg::*;
(
  input  logic [3:0]         op,
  input  logic [FLAGS_W-1:0] flags,
  output logic               is_ctrl,
  output logic               is_link,
  output logic               taken,
  output tgt_sel_e           sel
);
  logic eq, zr, ng;
  assign eq = flags[FLAG_EQ];
  assign zr = flags[FLAG_ZERO];
  assign ng = flags[FLAG_NEG];

  always_comb begin
    is_ctrl = 1'b1;
    is_link = 1'b0;
    taken   = 1'b0;
    sel     = TGT_REL;
    unique case (op)
      OP_BEQ:   taken = eq;
      OP_BNE:   taken = !eq;
      OP_BLEZ:  taken = zr || ng;
      OP_BGTZ:  taken = !zr && !ng;
      OP_BLTZ:  taken = ng;
      OP_BGEZ:  taken = !ng;
      OP_BLTZL: begin taken = ng;  is_link = 1'b1; end
      OP_BGEZL: begin taken = !ng; is_link = 1'b1; end
      OP_JABS:  begin taken = 1'b1; sel = TGT_ABS; end
      OP_JREG:  begin taken = 1'b1; sel = TGT_REG; end
      default:  begin is_ctrl = 1'b0; sel = TGT_NEXT; end
    endcase
    if (!taken && is_ctrl) sel = TGT_NEXT;
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_resolve_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 16
) (
  input  tgt_sel_e                 sel,
  input  logic [PC_W-1:0]          pc_cur,
  input  logic signed [OFF_W-1:0]  offset,
  input  logic [PC_W-1:0]          abs_tgt,
  input  logic [PC_W-1:0]          reg_tgt,
  output logic [PC_W-1:0]          next_addr,
  output logic [PC_W-1:0]          after_slot
);
  logic [PC_W-1:0] off_ext;
  assign off_ext    = PC_W'(offset);
  assign after_slot = pc_cur + PC_W'(2);

  always_comb begin
    unique case (sel)
      TGT_REL:  next_addr = pc_cur + off_ext;
      TGT_ABS:  next_addr = abs_tgt;
      TGT_REG:  next_addr = reg_tgt;
      default:  next_addr = after_slot;
    endcase
  end
endmodule

// File: rtl/br_pc.sv
module br_pc #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            ctrl,
  input  logic [PC_W-1:0] resolved,
  output logic [PC_W-1:0] pc_q,
  output logic            slot_q,
  output logic            redir_ev
);
  logic [PC_W-1:0] pend_q;

  assign redir_ev = adv && ctrl && !slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      pend_q <= '0;
      slot_q <= 1'b0;
    end else if (adv) begin
      if (slot_q) begin
        pc_q   <= pend_q;
        slot_q <= 1'b0;
      end else if (ctrl) begin
        pc_q   <= pc_q + PC_W'(1);
        pend_q <= resolved;
        slot_q <= 1'b1;
      end else begin
        pc_q   <= pc_q + PC_W'(1);
      end
    end
  end

  // r2: a bubble leaves the counter where it was
  p_bubble_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc_q));
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_resolve_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int OFF_W    = 16,
  parameter int DATA_W   = 32,
  parameter int LINK_REG = 31
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [3:0]              in_op,
  input  logic [FLAGS_W-1:0]      in_flags,
  input  logic signed [OFF_W-1:0] in_offset,
  input  logic [PC_W-1:0]         in_abs_target,
  input  logic [PC_W-1:0]         in_reg_target,
  output logic [PC_W-1:0]         pc,
  output logic                    redir_valid,
  output logic                    redir_taken,
  output logic [PC_W-1:0]         redir_target,
  output logic                    link_we,
  output logic [4:0]              link_idx,
  output logic [DATA_W-1:0]       link_data
);
  logic            is_ctrl, is_link, taken;
  tgt_sel_e        sel;
  logic [PC_W-1:0] next_addr, after_slot, pc_q;
  logic            slot_q, redir_ev;

  br_cond u_cond (
    .op(in_op), .flags(in_flags), .is_ctrl(is_ctrl),
    .is_link(is_link), .taken(taken), .sel(sel)
  );

  br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .sel(sel), .pc_cur(pc_q), .offset(in_offset),
    .abs_tgt(in_abs_target), .reg_tgt(in_reg_target),
    .next_addr(next_addr), .after_slot(after_slot)
  );

  br_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .adv(in_valid), .ctrl(is_ctrl),
    .resolved(next_addr), .pc_q(pc_q), .slot_q(slot_q),
    .redir_ev(redir_ev)
  );

  assign pc       = pc_q;
  assign link_idx = 5'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid  <= 1'b0;
      redir_taken  <= 1'b0;
      redir_target <= '0;
      link_we      <= 1'b0;
      link_data    <= '0;
    end else begin
      redir_valid <= redir_ev;
      link_we     <= redir_ev && is_link;
      if (redir_ev) begin
        redir_taken  <= taken;
        redir_target <= next_addr;
        link_data    <= DATA_W'(after_slot);
      end
    end
  end

  // r7 / r8: a redirect pulse lasts one cycle; the delay slot never redirects
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);

  // r7: a not-taken redirect points one past the delay slot
  p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !redir_taken) |-> redir_target == pc + PC_W'(1));

  // r9: link write only with a redirect, carrying the post-slot address
  p_link_pair_r9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (redir_valid && link_data == DATA_W'(pc + PC_W'(1))));

  // r2: a bubble produces no redirect
  p_bubble_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !redir_valid && !link_we);
endmodule

// File: tb/test_br_resolve.sv
module test_br_resolve;
  localparam int PC_W = 16, OFF_W = 16, DATA_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [2:0] in_flags = '0;
  logic signed [OFF_W-1:0] in_offset = '0;
  logic [PC_W-1:0] in_abs_target = '0, in_reg_target = '0;
  logic [PC_W-1:0] pc, redir_target;
  logic redir_valid, redir_taken, link_we;
  logic [4:0] link_idx;
  logic [DATA_W-1:0] link_data;

  int n_chk = 0, n_bad = 0;
  logic [PC_W-1:0] m_pc;

  always #4 clk = ~clk;

  br_resolve #(.PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_br_resolve (
    .clk, .rst, .in_valid, .in_op, .in_flags, .in_offset,
    .in_abs_target, .in_reg_target, .pc, .redir_valid, .redir_taken,
    .redir_target, .link_we, .link_idx, .link_data
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, outputs settle after the posedge; sample at next negedge
  task automatic step(input logic v, input logic [3:0] op, input logic [2:0] fl,
                      input logic signed [OFF_W-1:0] off,
                      input logic [PC_W-1:0] abs_t, input logic [PC_W-1:0] reg_t);
    in_valid = v; in_op = op; in_flags = fl; in_offset = off;
    in_abs_target = abs_t; in_reg_target = reg_t;
    @(negedge clk);
  endtask

  function automatic logic cond_of(input int op, input logic [2:0] fl);
    logic eq, zr, ng;
    eq = fl[0]; zr = fl[1]; ng = fl[2];
    case (op)
      1: return eq;
      2: return !eq;
      3: return zr || ng;
      4: return !zr && !ng;
      5, 7: return ng;
      6, 8: return !ng;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pc", 64'(pc), 0);
    chk("R1 redir", 64'(redir_valid), 0);
    chk("R1 link", 64'(link_we), 0);
    m_pc = '0;

    // R3: plain instructions advance
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 4'd0, 3'b000, '0, '0, '0);
      m_pc = m_pc + 1'b1;
      chk("R3 pc", 64'(pc), 64'(m_pc));
      chk("R3 redir", 64'(redir_valid), 0);
    end

    // R2: bubbles hold, even carrying a control code
    step(1'b0, 4'd9, 3'b111, 16'sd5, 16'h0abc, '0);
    chk("R2 pc", 64'(pc), 64'(m_pc));
    chk("R2 redir", 64'(redir_valid), 0);
    chk("R2 link", 64'(link_we), 0);

    // R4..R9 sweep: every control code, every flag pattern, two offsets
    for (int op = 1; op <= 10; op++) begin
      for (int fl = 0; fl < 8; fl++) begin
        for (int oi = 0; oi < 2; oi++) begin
          logic signed [OFF_W-1:0] off;
          logic [PC_W-1:0] p, abs_t, reg_t, tgt, exp_next;
          logic tk, lk;
          off   = (oi == 0) ? 16'sd7 : -16'sd3;
          abs_t = PC_W'(16'h0100 + op * 16 + fl);
          reg_t = PC_W'(16'h2000 + op * 8 + fl * 2 + oi);
          p     = m_pc;
          tk    = cond_of(op, 3'(fl));
          lk    = (op == 7 || op == 8);
          if (op == 9)       tgt = abs_t;
          else if (op == 10) tgt = reg_t;
          else               tgt = p + PC_W'(off);
          exp_next = tk ? tgt : p + 2'd2;
          step(1'b1, 4'(op), 3'(fl), off, abs_t, reg_t);
          chk($sformatf("R7 pulse op%0d fl%0d", op, fl), 64'(redir_valid), 1);
          chk($sformatf("R4 taken op%0d fl%0d", op, fl), 64'(redir_taken), 64'(tk));
          chk($sformatf("R5/R6 target op%0d fl%0d", op, fl), 64'(redir_target), 64'(exp_next));
          chk("R7 slot pc", 64'(pc), 64'(p + 1'b1));
          chk($sformatf("R9 link_we op%0d", op), 64'(link_we), 64'(lk));
          if (lk) begin
            chk("R9 link idx", 64'(link_idx), 31);
            chk("R9 link data", 64'(link_data), 64'(p + 2'd2));
          end
          // R8: delay slot executes and lands on resolved address
          step(1'b1, 4'd0, 3'b000, '0, '0, '0);
          chk("R8 pc after slot", 64'(pc), 64'(exp_next));
          chk("R8 no redirect", 64'(redir_valid), 0);
          m_pc = exp_next;
        end
      end
    end

    // R8: a control code inside the delay slot is ignored as control
    begin
      logic [PC_W-1:0] p;
      p = m_pc;
      step(1'b1, 4'd9, 3'b000, '0, 16'h0040, '0);
      chk("R6 jump pulse", 64'(redir_target), 16'h0040);
      step(1'b1, 4'd9, 3'b000, '0, 16'h0777, '0);
      chk("R8 slot jump ignored pc", 64'(pc), 16'h0040);
      chk("R8 slot jump no pulse", 64'(redir_valid), 0);
      chk("R8 slot jump no link", 64'(link_we), 0);
      step(1'b1, 4'd0, 3'b000, '0, '0, '0);
      chk("R3 after slot", 64'(pc), 16'h0041);
      if (p == 16'hffff) $display("unused");
    end

    // R1: reset mid-run
    rst = 1'b1;
    step(1'b1, 4'd9, 3'b000, '0, 16'h0123, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 pc after reset", 64'(pc), 0);
    chk("R1 redir after reset", 64'(redir_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule